// File: doc/BRIEF.md
# Down-Counting Timer with Compare-Action Output

The block is a single timer channel with a down counter, a reload value, a compare value and one output pin. A 3-bit action code sets how the pin moves. Some codes change the pin only when the counter times out. Other codes also force a level on the pin at the moment the code is written, and then act again at each timeout. Software can rewrite the action code while the counter runs. This lets it set the pin's starting level and then choose set, clear or toggle for each later period.

The counter runs in one-shot or periodic mode. In periodic mode it reloads after each timeout, and a reload value of all ones gives a free-running full-width period. When the counter equals the compare value, a match flag is raised, but the pin does not change. Timeout and match each set a raw flag. A mask picks which flags drive the interrupt line, and a write-one-to-clear strobe clears the flags. Everything is programmed through a simple synchronous write port. Each write is one cycle with an address and a data word.

Top module: `cmp_timer`

## Requirements
- R1: After reset, `ccp_pin`, `irq`, `raw_flags`, `running` and `count_o` are all 0. The reload value resets to all ones.
- R2: Register addresses are: 0 mode, 1 control, 2 reload, 3 compare, 4 action, 5 mask, 6 clear. Writing control bit 0 = 1 while stopped sets `running` and loads the counter from the reload value in that same cycle. While running, the counter falls by 1 each cycle.
- R3: A timeout is a running cycle in which `count_o` is 0. In periodic mode (mode bits [1:0] = 2), the next cycle loads the reload value, so the period is reload + 1 cycles. A reload write made while running is first seen at the next reload.
- R4: In one-shot mode (mode bits [1:0] = 1), the timeout clears `running` and the counter holds at 0.
- R5: At each timeout, action code 1 toggles the pin, code 2 clears it and code 3 sets it.
- R6: Writing action code 4 or 6 sets the pin at once, and writing code 5 or 7 clears it at once. This happens whether or not the counter runs. At timeout, codes 4 and 5 toggle the pin, code 6 clears it and code 7 sets it.
- R7: The action code can be rewritten mid-period. A code with no immediate part leaves the pin unchanged until the next timeout, and that timeout uses the new code.
- R8: Compare actions (immediate and timeout) occur only when mode bits [1:0] are 1 or 2, mode bit 2 (capture select) is 0, and the action code is nonzero.
- R9: While mode bit 3 (PWM select) is 1, `ccp_pin` is 0 and the action logic does not change the stored pin level. Clearing the bit shows the level that was held.
- R10: When the running counter equals the compare value, `raw_flags[1]` is set on the next cycle and the pin is not changed.
- R11: A timeout sets `raw_flags[0]` on the next cycle. `irq` is the OR of the raw flags ANDed with mask bits (bit 0 timeout, bit 1 match).
- R12: Writing 1 to a bit of the clear register clears that raw flag. If a new event comes in the same cycle, the flag stays set.
- R13: While stopped, the pin holds its level and the counter holds its value. A reload write made while stopped also loads the counter at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W | Write data |
| ccp_pin | output | 1 | Compare-action output pin |
| irq | output | 1 | Masked interrupt |
| raw_flags | output | 2 | Raw flags: bit 0 timeout, bit 1 match |
| count_o | output | CNT_W | Current counter value |
| running | output | 1 | Counter enable state |

## Verification
Two pairs of functions can land in the same cycle. In the first, a flag-clear write and a new timeout event share a cycle. The bench provokes this by issuing the clear while the counter reads 0. The flag must still read set afterwards, and a second clear one cycle later must remove it. In the second, a compare match and the pin logic share a cycle. The bench watches the cycle after the counter passes the compare value and requires the match flag to rise while the pin keeps its level.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

   localparam int ADDR_W   = 3;
   localparam int NUM_SRC  = 2;
   localparam int SRC_TO   = 0;
   localparam int SRC_MAT  = 1;

   localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
   localparam logic [ADDR_W-1:0] A_CTRL  = 3'd1;
   localparam logic [ADDR_W-1:0] A_LOAD  = 3'd2;
   localparam logic [ADDR_W-1:0] A_MATCH = 3'd3;
   localparam logic [ADDR_W-1:0] A_ACT   = 3'd4;
   localparam logic [ADDR_W-1:0] A_MASK  = 3'd5;
   localparam logic [ADDR_W-1:0] A_CLR   = 3'd6;

   typedef enum logic [1:0] {
      CM_OFF      = 2'd0,
      CM_ONESHOT  = 2'd1,
      CM_PERIODIC = 2'd2,
      CM_RSVD     = 2'd3
   } cnt_mode_e;

   typedef struct packed {
      cnt_mode_e mode;
      logic      cap_sel;
      logic      pwm_sel;
   } mode_cfg_t;

   // level reached at a timeout for a given action code
   function automatic logic next_on_timeout(input logic [2:0] code, input logic cur);
      case (code)
         3'd1, 3'd4, 3'd5: return ~cur;
         3'd2, 3'd6:       return 1'b0;
         3'd3, 3'd7:       return 1'b1;
         default:          return cur;
      endcase
   endfunction

   // codes with bit 2 set carry an immediate level: even codes set, odd clear
   function automatic logic has_immediate(input logic [2:0] code);
      return code[2];
   endfunction

   function automatic logic immediate_level(input logic [2:0] code);
      return ~code[0];
   endfunction

endpackage

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
   import cmp_timer_pkg::*;
#(
   parameter int CNT_W = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   output mode_cfg_t         cfg_q,
   output logic [CNT_W-1:0]  load_q,
   output logic [CNT_W-1:0]  match_q,
   output logic [2:0]        act_q,
   output logic [NUM_SRC-1:0] mask_q,
   output logic              ctrl_wr,
   output logic              ctrl_en,
   output logic              load_wr,
   output logic              act_wr,
   output logic [NUM_SRC-1:0] clr_vec
);

   always_comb begin
      ctrl_wr = wr_en && (wr_addr == A_CTRL);
      ctrl_en = wr_data[0];
      load_wr = wr_en && (wr_addr == A_LOAD);
      act_wr  = wr_en && (wr_addr == A_ACT);
      clr_vec = (wr_en && (wr_addr == A_CLR)) ? wr_data[NUM_SRC-1:0] : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q   <= '{mode: CM_OFF, cap_sel: 1'b0, pwm_sel: 1'b0};
         load_q  <= '1;
         match_q <= '1;
         act_q   <= '0;
         mask_q  <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            A_MODE: begin
               cfg_q.mode    <= cnt_mode_e'(wr_data[1:0]);
               cfg_q.cap_sel <= wr_data[2];
               cfg_q.pwm_sel <= wr_data[3];
            end
            A_LOAD:  load_q  <= wr_data;
            A_MATCH: match_q <= wr_data;
            A_ACT:   act_q   <= wr_data[2:0];
            A_MASK:  mask_q  <= wr_data[NUM_SRC-1:0];
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter #(
   parameter int CNT_W = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             oneshot,
   input  logic [CNT_W-1:0] load_q,
   input  logic [CNT_W-1:0] match_q,
   input  logic [CNT_W-1:0] load_wdata,
   input  logic             load_wr,
   input  logic             ctrl_wr,
   input  logic             ctrl_en,
   output logic [CNT_W-1:0] cnt_q,
   output logic             en_q,
   output logic             timeout,
   output logic             match_hit
);

   localparam logic [CNT_W-1:0] ZERO = '0;
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_n;
   logic             en_n;

   assign timeout   = en_q && (cnt_q == ZERO);
   assign match_hit = en_q && (cnt_q == match_q);

   always_comb begin
      cnt_n = cnt_q;
      en_n  = en_q;
      if (en_q) begin
         if (cnt_q == ZERO) begin
            if (oneshot) en_n  = 1'b0;
            else         cnt_n = load_q;
         end else begin
            cnt_n = cnt_q - ONE;
         end
      end else if (load_wr) begin
         cnt_n = load_wdata;
      end
      if (ctrl_wr) begin
         if (!ctrl_en) begin
            en_n = 1'b0;
         end else if (!en_q) begin
            en_n  = 1'b1;
            cnt_n = load_q;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= ZERO;
         en_q  <= 1'b0;
      end else begin
         cnt_q <= cnt_n;
         en_q  <= en_n;
      end
   end

endmodule

// File: rtl/cmp_timer_action.sv
module cmp_timer_action
   import cmp_timer_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  mode_cfg_t cfg_q,
   input  logic [2:0] act_q,
   input  logic      act_wr,
   input  logic [2:0] act_wdata,
   input  logic      timeout,
   output logic      pin_q,
   output logic      pin_out
);

   logic mode_ok;
   logic imm_fire;
   logic to_fire;

   always_comb begin
      mode_ok  = ((cfg_q.mode == CM_ONESHOT) || (cfg_q.mode == CM_PERIODIC))
                 && !cfg_q.cap_sel && !cfg_q.pwm_sel;
      imm_fire = act_wr && mode_ok && has_immediate(act_wdata);
      to_fire  = timeout && mode_ok && (act_q != 3'd0);
   end

   // an immediate write outranks a timeout landing in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n)        pin_q <= 1'b0;
      else if (imm_fire) pin_q <= immediate_level(act_wdata);
      else if (to_fire)  pin_q <= next_on_timeout(act_q, pin_q);
   end

   assign pin_out = pin_q && !cfg_q.pwm_sel;

endmodule

// File: rtl/cmp_timer_irq.sv
module cmp_timer_irq #(
   parameter int NSRC = 2
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] evt,
   input  logic [NSRC-1:0] clr,
   input  logic [NSRC-1:0] mask,
   output logic [NSRC-1:0] raw_q,
   output logic            irq
);

   for (genvar i = 0; i < NSRC; i++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n) raw_q[i] <= 1'b0;
         else        raw_q[i] <= evt[i] | (raw_q[i] & ~clr[i]);
      end
   end

   assign irq = |(raw_q & mask);

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
   import cmp_timer_pkg::*;
#(
   parameter int CNT_W = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   output logic              ccp_pin,
   output logic              irq,
   output logic [1:0]        raw_flags,
   output logic [CNT_W-1:0]  count_o,
   output logic              running
);

   if (CNT_W < 8 || CNT_W > 32) begin : g_bad_width
      $error("cmp_timer: CNT_W must lie in 8..32");
   end

   mode_cfg_t          cfg_q;
   logic [CNT_W-1:0]   load_q;
   logic [CNT_W-1:0]   match_q;
   logic [2:0]         act_q;
   logic [NUM_SRC-1:0] mask_q;
   logic               ctrl_wr;
   logic               ctrl_en;
   logic               load_wr;
   logic               act_wr;
   logic [NUM_SRC-1:0] clr_vec;
   logic               timeout;
   logic               match_hit;
   logic               pin_q;
   logic               oneshot;
   logic [NUM_SRC-1:0] evt;

   assign oneshot = (cfg_q.mode == CM_ONESHOT);

   always_comb begin
      evt          = '0;
      evt[SRC_TO]  = timeout;
      evt[SRC_MAT] = match_hit;
   end

   cmp_timer_regs #(.CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .cfg_q(cfg_q), .load_q(load_q), .match_q(match_q), .act_q(act_q), .mask_q(mask_q),
      .ctrl_wr(ctrl_wr), .ctrl_en(ctrl_en), .load_wr(load_wr), .act_wr(act_wr),
      .clr_vec(clr_vec)
   );

   cmp_timer_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .oneshot(oneshot), .load_q(load_q), .match_q(match_q),
      .load_wdata(wr_data), .load_wr(load_wr), .ctrl_wr(ctrl_wr), .ctrl_en(ctrl_en),
      .cnt_q(count_o), .en_q(running), .timeout(timeout), .match_hit(match_hit)
   );

   cmp_timer_action u_act (
      .clk(clk), .rst_n(rst_n), .cfg_q(cfg_q), .act_q(act_q), .act_wr(act_wr),
      .act_wdata(wr_data[2:0]), .timeout(timeout), .pin_q(pin_q), .pin_out(ccp_pin)
   );

   cmp_timer_irq #(.NSRC(NUM_SRC)) u_irq (
      .clk(clk), .rst_n(rst_n), .evt(evt), .clr(clr_vec), .mask(mask_q),
      .raw_q(raw_flags), .irq(irq)
   );

endmodule

// File: rtl/cmp_timer_sva.sv
module cmp_timer_sva #(
   parameter int CNT_W = 16
)(
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             ccp_pin,
   input logic             irq,
   input logic [1:0]       raw_flags,
   input logic [CNT_W-1:0] count_o,
   input logic             running,
   input logic             oneshot,
   input logic [CNT_W-1:0] load_q,
   input logic             timeout,
   input logic             match_hit,
   input logic             pwm_sel,
   input logic             pin_q
);

   a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (running && count_o != '0 && !wr_en) |=> (count_o == $past(count_o) - CNT_W'(1)));

   a_r3_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout && !oneshot && !wr_en) |=> (count_o == $past(load_q)));

   a_r4_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout && oneshot && !wr_en) |=> (!running && count_o == '0));

   a_r9_pwm_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_sel |-> !ccp_pin);

   a_r10_match_keeps_pin: assert property (@(posedge clk) disable iff (!rst_n)
      (match_hit && !timeout && !wr_en) |=> $stable(pin_q));

   a_r11_timeout_flag: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |=> raw_flags[0]);

   a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_flags == 2'b00) |-> !irq);

   a_r13_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !wr_en) |=> ($stable(ccp_pin) && $stable(count_o)));

endmodule

bind cmp_timer cmp_timer_sva #(.CNT_W(CNT_W)) u_sva (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ccp_pin(ccp_pin), .irq(irq),
   .raw_flags(raw_flags), .count_o(count_o), .running(running), .oneshot(oneshot),
   .load_q(load_q), .timeout(timeout), .match_hit(match_hit),
   .pwm_sel(cfg_q.pwm_sel), .pin_q(pin_q)
);

// File: tb/cmp_timer_bench.sv
module cmp_timer_bench;

   localparam int CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic [2:0]       wr_addr = '0;
   logic [CNT_W-1:0] wr_data = '0;
   logic             ccp_pin;
   logic             irq;
   logic [1:0]       raw_flags;
   logic [CNT_W-1:0] count_o;
   logic             running;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   cmp_timer #(.CNT_W(CNT_W)) u_cmp_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ccp_pin(ccp_pin), .irq(irq), .raw_flags(raw_flags), .count_o(count_o),
      .running(running)
   );

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [CNT_W-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; wr_en = 1'b0;
      step(3);
      rst_n = 1'b1;
      step(1);
   endtask

   task automatic wait_zero(output int n);
      n = 0;
      while (count_o != '0 && n < 70000) begin
         step(1);
         n++;
      end
   endtask

   // advance past the next timeout so its pin action is visible
   task automatic next_to();
      int n;
      wait_zero(n);
      step(1);
   endtask

   task automatic setup(input int mode, input int load, input int act);
      wr(3'd0, CNT_W'(mode));
      wr(3'd2, CNT_W'(load));
      wr(3'd4, CNT_W'(act));
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 pin", ccp_pin, 0);
      chk("R1 irq", irq, 0);
      chk("R1 flags", raw_flags, 0);
      chk("R1 running", running, 0);
      chk("R1 count", count_o, 0);
      wr(3'd1, 1);
      chk("R1 reload resets all ones", count_o, 16'hFFFF);
   endtask

   task automatic t_count();
      int n;
      do_reset();
      setup(2, 5, 1);
      wr(3'd1, 1);
      chk("R2 loaded on enable", count_o, 5);
      chk("R2 running", running, 1);
      wait_zero(n);
      chk("R2 cycles to zero", n, 5);
      chk("R5 pin before timeout", ccp_pin, 0);
      step(1);
      chk("R5 toggle first", ccp_pin, 1);
      chk("R3 reload", count_o, 5);
      chk("R11 timeout flag", raw_flags[0], 1);
      next_to();
      chk("R5 toggle second", ccp_pin, 0);
      wr(3'd2, 3);
      next_to();
      chk("R3 new reload at next timeout", count_o, 3);
      wait_zero(n);
      chk("R3 new period", n, 3);
   endtask

   task automatic t_codes();
      do_reset();
      setup(2, 3, 3);
      wr(3'd1, 1);
      next_to();
      chk("R5 code3 set", ccp_pin, 1);
      next_to();
      chk("R5 code3 stays set", ccp_pin, 1);
      do_reset();
      setup(2, 3, 6);
      chk("R6 code6 immediate set", ccp_pin, 1);
      wr(3'd4, 2);
      wr(3'd1, 1);
      next_to();
      chk("R5 code2 clear", ccp_pin, 0);
      next_to();
      chk("R5 code2 stays clear", ccp_pin, 0);
   endtask

   task automatic t_imm();
      do_reset();
      setup(2, 3, 4);
      chk("R6 code4 immediate", ccp_pin, 1);
      wr(3'd1, 1);
      next_to();
      chk("R6 code4 toggle", ccp_pin, 0);
      next_to();
      chk("R6 code4 toggle back", ccp_pin, 1);
      do_reset();
      setup(2, 3, 4);
      wr(3'd4, 5);
      chk("R6 code5 immediate", ccp_pin, 0);
      wr(3'd1, 1);
      next_to();
      chk("R6 code5 toggle", ccp_pin, 1);
      next_to();
      chk("R6 code5 toggle back", ccp_pin, 0);
      do_reset();
      setup(2, 3, 6);
      wr(3'd1, 1);
      next_to();
      chk("R6 code6 clear at timeout", ccp_pin, 0);
      next_to();
      chk("R6 code6 stays clear", ccp_pin, 0);
      do_reset();
      setup(2, 3, 4);
      wr(3'd4, 7);
      chk("R6 code7 immediate", ccp_pin, 0);
      wr(3'd1, 1);
      next_to();
      chk("R6 code7 set at timeout", ccp_pin, 1);
      next_to();
      chk("R6 code7 stays set", ccp_pin, 1);
   endtask

   task automatic t_fly();
      do_reset();
      setup(2, 7, 7);
      wr(3'd1, 1);
      next_to();
      chk("R7 start level", ccp_pin, 1);
      step(2);
      wr(3'd4, 2);
      chk("R7 code2 no immediate", ccp_pin, 1);
      next_to();
      chk("R7 code2 at timeout", ccp_pin, 0);
      wr(3'd4, 3);
      next_to();
      chk("R7 code3 at timeout", ccp_pin, 1);
      step(2);
      wr(3'd4, 5);
      chk("R7 code5 mid-period immediate", ccp_pin, 0);
      chk("R7 counter unaffected", running, 1);
      next_to();
      chk("R7 code5 toggle", ccp_pin, 1);
   endtask

   task automatic t_gate();
      do_reset();
      setup(0, 3, 1);
      wr(3'd1, 1);
      next_to();
      chk("R8 mode0 no action", ccp_pin, 0);
      next_to();
      chk("R8 mode0 still none", ccp_pin, 0);
      do_reset();
      setup(6, 3, 4);
      chk("R8 capture select blocks immediate", ccp_pin, 0);
      wr(3'd1, 1);
      next_to();
      chk("R8 capture select blocks timeout", ccp_pin, 0);
      do_reset();
      setup(2, 3, 4);
      wr(3'd4, 0);
      wr(3'd1, 1);
      next_to();
      chk("R8 code0 keeps level", ccp_pin, 1);
   endtask

   task automatic t_pwm();
      do_reset();
      setup(2, 50, 4);
      wr(3'd0, 10);
      chk("R9 pwm forces pin low", ccp_pin, 0);
      wr(3'd1, 1);
      next_to();
      chk("R9 pwm low at timeout", ccp_pin, 0);
      wr(3'd4, 5);
      chk("R9 pwm low after immediate code", ccp_pin, 0);
      wr(3'd0, 2);
      chk("R9 stored level kept", ccp_pin, 1);
   endtask

   task automatic t_oneshot();
      int n;
      do_reset();
      setup(1, 4, 1);
      wr(3'd1, 1);
      wait_zero(n);
      chk("R4 cycles to zero", n, 4);
      step(1);
      chk("R4 stopped", running, 0);
      chk("R4 count held", count_o, 0);
      chk("R4 pin toggled", ccp_pin, 1);
      chk("R4 timeout flag", raw_flags[0], 1);
      step(5);
      chk("R4 still stopped", running, 0);
      chk("R4 still zero", count_o, 0);
      chk("R13 pin held after stop", ccp_pin, 1);
   endtask

   task automatic t_match_irq();
      int g;
      do_reset();
      setup(2, 9, 3);
      wr(3'd3, 4);
      wr(3'd1, 1);
      g = 0;
      while (count_o != 4 && g < 100) begin step(1); g++; end
      chk("R10 no flag before match", raw_flags, 0);
      step(1);
      chk("R10 match flag", raw_flags[1], 1);
      chk("R10 pin unchanged on match", ccp_pin, 0);
      chk("R11 irq masked", irq, 0);
      next_to();
      chk("R10 pin set at timeout not match", ccp_pin, 1);
      wr(3'd5, 2);
      chk("R11 irq via match mask", irq, 1);
      wr(3'd6, 2);
      chk("R12 match flag cleared", raw_flags[1], 0);
      chk("R11 irq drops", irq, 0);
      wr(3'd5, 1);
      chk("R11 irq via timeout mask", irq, 1);
   endtask

   task automatic t_clear();
      int n;
      do_reset();
      setup(2, 3, 0);
      wr(3'd1, 1);
      next_to();
      chk("R12 flag set", raw_flags[0], 1);
      wait_zero(n);
      wr(3'd6, 1);
      chk("R12 event beats clear", raw_flags[0], 1);
      wr(3'd6, 1);
      chk("R12 clear without event", raw_flags[0], 0);
   endtask

   task automatic t_hold();
      logic [CNT_W-1:0] c;
      do_reset();
      setup(2, 3, 1);
      wr(3'd1, 1);
      next_to();
      chk("R13 pin high before stop", ccp_pin, 1);
      wr(3'd1, 0);
      c = count_o;
      step(10);
      chk("R13 stopped", running, 0);
      chk("R13 pin held", ccp_pin, 1);
      chk("R13 count held", count_o, c);
      wr(3'd2, 20);
      chk("R13 load while stopped", count_o, 20);
   endtask

   initial begin
      step(1);
      t_reset();
      t_count();
      t_codes();
      t_imm();
      t_fly();
      t_gate();
      t_pwm();
      t_oneshot();
      t_match_irq();
      t_clear();
      t_hold();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule